// File: doc/BRIEF.md
# Clock Ratio Control and Lock Sequencer

This block governs the system clock generator of a chip. It holds a frequency multiplier code and a post-divider selection, and it enforces the order in which software may change them. It also models the settling time that follows a multiplier change with a lock counter. The block computes the effective clock ratio as a numerator and a divisor to be applied to the oscillator clock. Clock-switching cells downstream use that ratio. The analog loop is not built here: a ratio code and a countdown stand for it.

A small register port with a write-protect enable gives software access. Software clears the divider selection first, then writes the multiplier, waits for lock, and then raises the divider selection. While the counter runs, the output ratio drops to a safe half-rate fallback. A separate detector event marks a lost input clock. Software can mask that detector around a multiplier change.

Top module: `clk_ratio_ctrl`

## Requirements
- R1: After reset the multiplier code is 0, the divider selection is 0, lock status is 1, the limp, detector-off and error flags are 0, and the output ratio is 1/4.
- R2: A multiplier write whose full data word exceeds 10 is rejected. The multiplier keeps its value and the sticky error flag (status bit 3) is set.
- R3: A multiplier write that would change the code is rejected while the divider selection is not 0. The multiplier keeps its value and the error flag is set.
- R4: The 2-bit divider selection sets the ratio divisor: codes 0 and 1 give 4, code 2 gives 2, and code 3 gives 1. Divider writes are accepted at any time.
- R5: An accepted write that changes the multiplier clears lock status and forces the ratio to 1/2, starting in the cycle after the write edge. This lasts for exactly LOCK_CYCLES cycles. After that, lock status returns to 1 and the ratio numerator equals the new code.
- R6: A multiplier write equal to the current code does not restart the lock counter, and lock status stays 1.
- R7: Multiplier code 0 means bypass: once locked, the ratio numerator is 1.
- R8: While the write-protect enable is low, every register write is ignored.
- R9: A lost-clock event sets the limp flag (status bit 1) while the detector-off bit (status bit 2) is 0. The flag stays set until reset. An event is ignored while the detector-off bit is 1.
- R10: Writing 1 to status bit 3 clears the error flag.
- R11: The read data is combinational on the address. Address 0 returns the multiplier in bits 3:0, address 1 returns the divider selection in bits 1:0, and address 2 returns the status: bit 0 is lock, bit 1 is limp, bit 2 is detector-off, and bit 3 is error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-domain clock |
| rstN | input | 1 | Active-low synchronous reset |
| protUnlock | input | 1 | Write-protect enable; writes land only while high |
| busWe | input | 1 | Register write strobe |
| busAddr | input | 2 | Register address (0 multiplier, 1 divider, 2 status) |
| busWdata | input | DATA_W | Write data |
| busRdata | output | DATA_W | Read data for busAddr |
| oscLost | input | 1 | Missing-input-clock event from the detector |
| ratioNum | output | 4 | Effective ratio numerator |
| ratioDen | output | 3 | Effective ratio divisor (1, 2 or 4) |
| divSelOut | output | 2 | Divider selection to the clock path |
| locked | output | 1 | Lock status |
| limp | output | 1 | Limp-mode flag |

## Verification
Register state, the ratio outputs and lock status all settle on the first clock edge after a write. The read data settles without any clock. The bench drives every input at the falling edge, so it checks register effects at the next falling edge. It checks read data one time step after it sets the address. For the lock sequence, the bench counts edges from the accepting write. It checks the fallback ratio and the cleared lock status right after the write, and again after LOCK_CYCLES-1 further edges. It checks the new ratio after exactly LOCK_CYCLES edges.

// File: rtl/clk_ratio_pkg.sv
package clk_ratio_pkg;
  localparam int MULT_W   = 4;
  localparam int MULT_MAX = 10;
  localparam int DIV_W    = 2;
  localparam int DEN_W    = 3;

  typedef enum logic [1:0] {
    ADDR_MULT = 2'd0,
    ADDR_DIV  = 2'd1,
    ADDR_STAT = 2'd2
  } regAddr_e;

  // strobes and state the control hands to the datapath
  typedef struct packed {
    logic              restartLock;
    logic [MULT_W-1:0] multVal;
    logic [DIV_W-1:0]  divSel;
  } pathCtrl_t;

  function automatic logic [DEN_W-1:0] denFromSel(input logic [DIV_W-1:0] sel);
    case (sel)
      2'd2:    return DEN_W'(2);
      2'd3:    return DEN_W'(1);
      default: return DEN_W'(4);
    endcase
  endfunction
endpackage

// File: rtl/clk_ratio_regs.sv
module clk_ratio_regs
  import clk_ratio_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              protUnlock,
  input  logic              busWe,
  input  logic [1:0]        busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              oscLost,
  input  logic              lockedIn,
  output pathCtrl_t         ctrl,
  output logic              limpFlag
);
  logic [MULT_W-1:0] multReg;
  logic [DIV_W-1:0]  divSel;
  logic              detOff;
  logic              errFlag;

  logic wrMult, wrDiv, wrStat;
  logic multDiff, multReject, multAccept;
  logic [MULT_W-1:0] newMult;

  always_comb begin
    wrMult     = protUnlock && busWe && (busAddr == ADDR_MULT);
    wrDiv      = protUnlock && busWe && (busAddr == ADDR_DIV);
    wrStat     = protUnlock && busWe && (busAddr == ADDR_STAT);
    newMult    = busWdata[MULT_W-1:0];
    multDiff   = newMult != multReg;
    multReject = wrMult && ((busWdata > DATA_W'(MULT_MAX)) ||
                            ((divSel != '0) && multDiff));
    multAccept = wrMult && !multReject && multDiff;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      multReg  <= '0;
      divSel   <= '0;
      detOff   <= 1'b0;
      errFlag  <= 1'b0;
      limpFlag <= 1'b0;
    end else begin
      if (multAccept) multReg <= newMult;
      if (wrDiv) divSel <= busWdata[DIV_W-1:0];
      if (wrStat) detOff <= busWdata[2];
      if (multReject) errFlag <= 1'b1;
      else if (wrStat && busWdata[3]) errFlag <= 1'b0;
      if (oscLost && !detOff) limpFlag <= 1'b1;
    end
  end

  always_comb begin
    ctrl.restartLock = multAccept;
    ctrl.multVal     = multReg;
    ctrl.divSel      = divSel;
  end

  always_comb begin
    busRdata = '0;
    case (busAddr)
      ADDR_MULT: busRdata[MULT_W-1:0] = multReg;
      ADDR_DIV:  busRdata[DIV_W-1:0]  = divSel;
      ADDR_STAT: busRdata[3:0]        = {errFlag, detOff, limpFlag, lockedIn};
      default:   busRdata = '0;
    endcase
  end

  p_mult_range_r2: assert property (@(posedge clk) disable iff (!rstN)
    multReg <= MULT_W'(MULT_MAX));

  p_div_guard_r3: assert property (@(posedge clk) disable iff (!rstN)
    (multReg != $past(multReg)) |-> ($past(divSel) == '0));

  p_protect_r8: assert property (@(posedge clk) disable iff (!rstN)
    !protUnlock |=> ($stable(multReg) && $stable(divSel) && $stable(detOff)));

  p_limp_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    limpFlag |=> limpFlag);
endmodule

// File: rtl/clk_ratio_path.sv
module clk_ratio_path
  import clk_ratio_pkg::*;
#(
  parameter int LOCK_CYCLES = 2048
) (
  input  logic              clk,
  input  logic              rstN,
  input  pathCtrl_t         ctrl,
  output logic              locked,
  output logic [MULT_W-1:0] ratioNum,
  output logic [DEN_W-1:0]  ratioDen,
  output logic [DIV_W-1:0]  divSelOut
);
  localparam int CNT_W = $clog2(LOCK_CYCLES + 1);

  logic [CNT_W-1:0] lockCnt;

  always_ff @(posedge clk) begin
    if (!rstN) lockCnt <= '0;
    else if (ctrl.restartLock) lockCnt <= CNT_W'(LOCK_CYCLES);
    else if (lockCnt != '0) lockCnt <= lockCnt - 1'b1;
  end

  always_comb begin
    locked    = (lockCnt == '0);
    divSelOut = ctrl.divSel;
    if (!locked) begin
      ratioNum = MULT_W'(1);
      ratioDen = DEN_W'(2);
    end else begin
      ratioNum = (ctrl.multVal == '0) ? MULT_W'(1) : ctrl.multVal;
      ratioDen = denFromSel(ctrl.divSel);
    end
  end

  p_restart_unlocks_r5: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.restartLock |=> !locked);

  p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rstN)
    lockCnt <= CNT_W'(LOCK_CYCLES));

  p_lock_steady_r6: assert property (@(posedge clk) disable iff (!rstN)
    (locked && !ctrl.restartLock) |=> locked);
endmodule

// File: rtl/clk_ratio_ctrl.sv
module clk_ratio_ctrl
  import clk_ratio_pkg::*;
#(
  parameter int LOCK_CYCLES = 2048,
  parameter int DATA_W      = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              protUnlock,
  input  logic              busWe,
  input  logic [1:0]        busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              oscLost,
  output logic [3:0]        ratioNum,
  output logic [2:0]        ratioDen,
  output logic [1:0]        divSelOut,
  output logic              locked,
  output logic              limp
);
  pathCtrl_t ctrl;

  clk_ratio_regs #(.DATA_W(DATA_W)) uRegs (
    .clk(clk), .rstN(rstN), .protUnlock(protUnlock), .busWe(busWe),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .oscLost(oscLost), .lockedIn(locked), .ctrl(ctrl), .limpFlag(limp)
  );

  clk_ratio_path #(.LOCK_CYCLES(LOCK_CYCLES)) uPath (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .locked(locked),
    .ratioNum(ratioNum), .ratioDen(ratioDen), .divSelOut(divSelOut)
  );
endmodule

// File: tb/clk_ratio_ctrl_test.sv
module clk_ratio_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int LOCKN = 16;
  localparam int DW = 16;

  logic clk = 1'b0, rstN = 1'b0, protUnlock = 1'b0, busWe = 1'b0, oscLost = 1'b0;
  logic [1:0] busAddr = 2'd0;
  logic [DW-1:0] busWdata = '0;
  logic [DW-1:0] busRdata;
  logic [3:0] ratioNum;
  logic [2:0] ratioDen;
  logic [1:0] divSelOut;
  logic locked, limp;
  int nChecks = 0, nFails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  clk_ratio_ctrl #(.LOCK_CYCLES(LOCKN), .DATA_W(DW)) uut (
    .clk(clk), .rstN(rstN), .protUnlock(protUnlock), .busWe(busWe),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .oscLost(oscLost), .ratioNum(ratioNum), .ratioDen(ratioDen),
    .divSelOut(divSelOut), .locked(locked), .limp(limp)
  );

  task automatic check(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    busWe = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWe = 1'b0; busWdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    busAddr = a;
    #1;
    v = int'(busRdata);
  endtask

  task automatic waitLock();
    repeat (LOCKN) @(negedge clk);
  endtask

  task automatic t_reset();
    int v;
    check("R1 mult", int'(ratioNum), 1);
    check("R1 den", int'(ratioDen), 4);
    check("R1 locked", int'(locked), 1);
    check("R1 limp", int'(limp), 0);
    rd(2'd0, v); check("R1 multreg", v, 0);
    rd(2'd1, v); check("R1 divsel", v, 0);
    rd(2'd2, v); check("R1 status", v, 1);
  endtask

  task automatic t_protect();
    int v;
    protUnlock = 1'b0;
    wr(2'd0, 16'd5);
    rd(2'd0, v); check("R8 mult ignored", v, 0);
    check("R8 still locked", int'(locked), 1);
    wr(2'd1, 16'd2);
    check("R8 div ignored", int'(ratioDen), 4);
    protUnlock = 1'b1;
  endtask

  task automatic t_rangeAndClear();
    int v;
    wr(2'd0, 16'd12);
    rd(2'd0, v); check("R2 mult kept", v, 0);
    rd(2'd2, v); check("R2 err set", (v >> 3) & 1, 1);
    wr(2'd0, 16'h0105);
    rd(2'd0, v); check("R2 wide word rejected", v, 0);
    wr(2'd2, 16'h0008);
    rd(2'd2, v); check("R10 err cleared", (v >> 3) & 1, 0);
  endtask

  task automatic t_lockSeq();
    int v;
    wr(2'd0, 16'd6);
    check("R5 unlocked", int'(locked), 0);
    check("R5 fallback num", int'(ratioNum), 1);
    check("R5 fallback den", int'(ratioDen), 2);
    rd(2'd2, v); check("R11 status lock bit", v & 1, 0);
    repeat (LOCKN-1) @(negedge clk);
    check("R5 still unlocked at end", int'(locked), 0);
    @(negedge clk);
    check("R5 locked", int'(locked), 1);
    check("R5 new num", int'(ratioNum), 6);
    check("R5 den", int'(ratioDen), 4);
    rd(2'd0, v); check("R11 mult read", v, 6);
  endtask

  task automatic t_sameValue();
    wr(2'd0, 16'd6);
    check("R6 no restart", int'(locked), 1);
    check("R6 num kept", int'(ratioNum), 6);
  endtask

  task automatic t_divDecode();
    int v;
    wr(2'd1, 16'd1); check("R4 code1", int'(ratioDen), 4);
    wr(2'd1, 16'd2); check("R4 code2", int'(ratioDen), 2);
    wr(2'd1, 16'd3); check("R4 code3", int'(ratioDen), 1);
    check("R4 divSelOut", int'(divSelOut), 3);
    rd(2'd1, v); check("R11 div read", v, 3);
  endtask

  task automatic t_guard();
    int v;
    wr(2'd0, 16'd8);
    rd(2'd0, v); check("R3 mult kept", v, 6);
    rd(2'd2, v); check("R3 err set", (v >> 3) & 1, 1);
    check("R3 no unlock", int'(locked), 1);
    wr(2'd1, 16'd0);
    wr(2'd2, 16'h0008);
  endtask

  task automatic t_example();
    wr(2'd0, 16'd10);
    waitLock();
    wr(2'd1, 16'd2);
    check("R5 example num", int'(ratioNum), 10);
    check("R4 example den", int'(ratioDen), 2);
    wr(2'd1, 16'd0);
  endtask

  task automatic t_bypass();
    wr(2'd0, 16'd0);
    check("R7 locking", int'(locked), 0);
    waitLock();
    check("R7 bypass num", int'(ratioNum), 1);
    check("R7 den", int'(ratioDen), 4);
  endtask

  task automatic t_limp();
    int v;
    wr(2'd2, 16'h0004);
    @(negedge clk); oscLost = 1'b1; @(negedge clk); oscLost = 1'b0;
    check("R9 masked", int'(limp), 0);
    wr(2'd2, 16'h0000);
    @(negedge clk); oscLost = 1'b1; @(negedge clk); oscLost = 1'b0;
    check("R9 set", int'(limp), 1);
    @(negedge clk);
    rd(2'd2, v); check("R9 sticky status", (v >> 1) & 1, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_protect();
    t_rangeAndClear();
    t_lockSeq();
    t_sameValue();
    t_divDecode();
    t_guard();
    t_example();
    t_bypass();
    t_limp();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule